// File: doc/BRIEF.md
# Multichannel Audio Record TDM Serializer

This block turns a bank of twenty audio sample words into one serial record stream with a frame sync and a bit-clock enable. Sixteen words are primary channels (numbered 0 to 15) and four are auxiliary channels (called X1 to X4). A one-cycle sample strobe latches the whole bank together with the frame settings. The block then shifts out one frame and goes quiet until the next strobe, so the frame on the wire cannot change if the inputs change while it is being sent.

Each frame uses one of two framing styles. Two-phase I2S framing splits the slots evenly between a left phase and a right phase. DSP framing sends every slot in one run after a single sync pulse. The auxiliary words can be turned off. When they are on, they are either appended at the end of each run or phase, or inserted after every fourth primary channel. A width select gives 8-, 16- or 24-bit words. A rate select gives the number of bit periods in each frame.

Top module: `tdm_rec_serializer`

## Requirements
- R1: While reset is asserted, and after reset until the first strobe, `sData`, `fSync` and `bitClkEn` are all 0.
- R2: A `sampleStb` pulse while idle latches the bank and all settings and starts a frame. `bitClkEn` then pulses once every CLK_DIV clock cycles, starting the cycle after the next, and stops after the last bit period of the frame.
- R3: The frame has this many bit periods. `rateSel` 0 gives 256, 1 gives 320, 2 gives 384 and 3 gives 64. `rateSel` 4 gives 128 when `wordSel` is 1 and 256 otherwise. Values 5 to 7 give 256.
- R4: `wordSel` 1 gives 8-bit words, 2 gives 24-bit words, and 0 or 3 give 16-bit words. A word is the most significant bits of its 24-bit sample, sent MSB first. Channel c occupies bits [24c+23:24c] of its bank port.
- R5: I2S framing (`dspMode`=0) with auxiliary words on and `auxOrder`=0: the left phase is 0..7, X1, X2 and the right phase is 8..15, X3, X4.
- R6: DSP framing (`dspMode`=1) with auxiliary words on and `auxOrder`=0: one run of 0..15, X1, X2, X3, X4.
- R7: I2S framing with auxiliary words on and `auxOrder`=1: the left phase is 0..3, X1, 4..7, X2 and the right phase is 8..11, X3, 12..15, X4.
- R8: DSP framing with auxiliary words on and `auxOrder`=1: one run of 0..3, X1, 4..7, X2, 8..11, X3, 12..15, X4.
- R9: With `auxEn`=0, only primary channels are sent and `auxOrder` has no effect: DSP sends 0..15 and I2S sends 0..7 left and 8..15 right.
- R10: In I2S framing, `fSync` is 0 for bit periods 0 to L/2-1 and 1 for the rest, and data starts one period after each change. In DSP framing, `fSync` is 1 only in period 0 and data starts in period 1.
- R11: A bit period not covered by a slot sends 0. A slot that runs past the end of its phase or frame is cut off there.
- R12: A strobe during a frame is ignored. Changing the bank or the settings during a frame has no effect on that frame.
- R13: `sData` and `fSync` change only in cycles where `bitClkEn` is 1, and hold their values between enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleStb | input | 1 | Latches the bank and settings and starts a frame |
| priBank | input | NUM_PRI*SMP_W | Primary channel samples, channel 0 in the lowest bits |
| auxBank | input | NUM_AUX*SMP_W | Auxiliary samples X1 (lowest bits) to X4 |
| dspMode | input | 1 | 1 selects DSP framing, 0 selects I2S framing |
| auxOrder | input | 1 | 1 interleaves the auxiliary words, 0 appends them |
| auxEn | input | 1 | Sends the auxiliary words |
| wordSel | input | 2 | Word width select |
| rateSel | input | 3 | Bit periods per frame select |
| sData | output | 1 | Serial record data |
| fSync | output | 1 | Frame sync |
| bitClkEn | output | 1 | One-cycle pulse marking each new bit period |

## Verification
A slot counter or phase register that goes wrong puts a wrong sample, or a zero, on `sData` within one word time of the fault. The bench compares every bit period against a model built from the slot lists above, so such a fault is caught in the same frame. A fault in the frame counter or the rate decode changes the number of enables in a frame, or moves the I2S sync edge, and shows at the end of the first frame sent. Settings that leak in during a frame are exposed by a strobe sent in the middle of a frame with a changed bank and changed settings.

// File: rtl/tdm_rec_pkg.sv
`timescale 1ns/1ps
package tdm_rec_pkg;

  localparam int unsigned CH_W = 6;

  localparam int unsigned FRAME_FOUR  = 256;
  localparam int unsigned FRAME_FIVE  = 320;
  localparam int unsigned FRAME_WIDE  = 384;
  localparam int unsigned FRAME_SHORT = 64;
  localparam int unsigned FRAME_PACK  = 128;

  typedef struct packed {
    logic            latch;
    logic            tick;
    logic            loadWord;
    logic            emitBit;
    logic            syncVal;
    logic [CH_W-1:0] chSel;
  } ctrl_strb_t;

  function automatic int unsigned frameLenOf(input logic [2:0] rate, input logic eightBit);
    case (rate)
      3'd0:    return FRAME_FOUR;
      3'd1:    return FRAME_FIVE;
      3'd2:    return FRAME_WIDE;
      3'd3:    return FRAME_SHORT;
      3'd4:    return eightBit ? FRAME_PACK : FRAME_FOUR;
      default: return FRAME_FOUR;
    endcase
  endfunction

  function automatic int unsigned wordLenOf(input logic [1:0] sel);
    case (sel)
      2'd1:    return 8;
      2'd2:    return 24;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/tdm_rec_ctrl.sv
`timescale 1ns/1ps
module tdm_rec_ctrl
  import tdm_rec_pkg::*;
#(
  parameter int unsigned NUM_PRI   = 16,
  parameter int unsigned NUM_AUX   = 4,
  parameter int unsigned CLK_DIV   = 2,
  parameter int unsigned MAX_FRAME = 384
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleStb,
  input  logic       dspMode,
  input  logic       auxOrder,
  input  logic       auxEn,
  input  logic [1:0] wordSel,
  input  logic [2:0] rateSel,
  output ctrl_strb_t strb
);

  localparam int unsigned NUM_CH   = NUM_PRI + NUM_AUX;
  localparam int unsigned IDX_W    = $clog2(MAX_FRAME + 1);
  localparam int unsigned DIV_W    = $clog2(CLK_DIV + 1);
  localparam int unsigned SLOT_W   = $clog2(NUM_CH + 1);
  localparam int unsigned GRP      = NUM_PRI / NUM_AUX;
  localparam int unsigned HALF_PRI = NUM_PRI / 2;
  localparam int unsigned HALF_AUX = NUM_AUX / 2;

  logic              active;
  logic [DIV_W-1:0]  divCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic [SLOT_W-1:0] slotCnt;
  logic [4:0]        bitInWord;
  logic              phase;
  logic              slotValid;
  logic              cDsp, cOrd, cAux;
  logic [1:0]        cWsel;
  logic [2:0]        cRate;

  logic [IDX_W-1:0]  frameLen, halfLen;
  logic [SLOT_W-1:0] slotsPerPhase;
  logic [4:0]        wordLen;
  logic              tick, phStart, nextPhase, lastBit, lastSlot;

  function automatic logic [CH_W-1:0] mapChan(input int ph, input int slot,
                                               input logic dsp, input logic ord, input logic aux);
    int pos;
    int ch;
    if (!aux) begin
      ch = dsp ? slot : ph * int'(HALF_PRI) + slot;
    end else if (!ord) begin
      if (dsp)                      ch = slot;
      else if (slot < int'(HALF_PRI)) ch = ph * int'(HALF_PRI) + slot;
      else ch = int'(NUM_PRI) + ph * int'(HALF_AUX) + slot - int'(HALF_PRI);
    end else begin
      pos = dsp ? slot : ph * int'(HALF_PRI + HALF_AUX) + slot;
      if (pos % int'(GRP + 1) == int'(GRP)) ch = int'(NUM_PRI) + pos / int'(GRP + 1);
      else ch = (pos / int'(GRP + 1)) * int'(GRP) + pos % int'(GRP + 1);
    end
    return CH_W'(ch);
  endfunction

  always_comb begin
    frameLen      = IDX_W'(frameLenOf(cRate, cWsel == 2'd1));
    halfLen       = frameLen >> 1;
    wordLen       = 5'(wordLenOf(cWsel));
    slotsPerPhase = cAux ? SLOT_W'(NUM_CH) : SLOT_W'(NUM_PRI);
    if (!cDsp) slotsPerPhase = slotsPerPhase >> 1;
    tick      = active && (divCnt == '0);
    nextPhase = (bitIdx != '0);
    phStart   = tick && ((bitIdx == '0) || (!cDsp && bitIdx == halfLen));
    lastBit   = (bitInWord == wordLen - 5'd1);
    lastSlot  = (slotCnt == slotsPerPhase - 1'b1);

    strb.latch    = sampleStb && !active;
    strb.tick     = tick;
    strb.syncVal  = cDsp ? (bitIdx == '0) : (bitIdx >= halfLen);
    strb.emitBit  = tick && !phStart && slotValid;
    strb.loadWord = phStart || (strb.emitBit && lastBit && !lastSlot);
    strb.chSel    = mapChan(phStart ? int'(nextPhase) : int'(phase),
                            phStart ? 0 : int'(slotCnt) + 1, cDsp, cOrd, cAux);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      divCnt    <= '0;
      bitIdx    <= '0;
      slotCnt   <= '0;
      bitInWord <= '0;
      phase     <= 1'b0;
      slotValid <= 1'b0;
      cDsp      <= 1'b0;
      cOrd      <= 1'b0;
      cAux      <= 1'b0;
      cWsel     <= '0;
      cRate     <= '0;
    end else if (strb.latch) begin
      active    <= 1'b1;
      divCnt    <= '0;
      bitIdx    <= '0;
      slotValid <= 1'b0;
      cDsp      <= dspMode;
      cOrd      <= auxOrder;
      cAux      <= auxEn;
      cWsel     <= wordSel;
      cRate     <= rateSel;
    end else if (active) begin
      divCnt <= (divCnt == DIV_W'(CLK_DIV - 1)) ? '0 : divCnt + 1'b1;
      if (tick) begin
        bitIdx <= bitIdx + 1'b1;
        if (bitIdx == frameLen - 1'b1) active <= 1'b0;
        if (phStart) begin
          phase     <= nextPhase;
          slotCnt   <= '0;
          bitInWord <= '0;
          slotValid <= 1'b1;
        end else if (slotValid) begin
          if (lastBit) begin
            bitInWord <= '0;
            if (lastSlot) slotValid <= 1'b0;
            else          slotCnt   <= slotCnt + 1'b1;
          end else begin
            bitInWord <= bitInWord + 1'b1;
          end
        end
      end
    end
  end

  // R3
  frame_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    active |-> (bitIdx < frameLen));

  // R12
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (active && sampleStb) |=> $stable({cDsp, cOrd, cAux, cWsel, cRate}));

  // R11
  chan_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadWord |-> (strb.chSel < CH_W'(NUM_CH)));

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && (CLK_DIV > 1)) |=> !tick);

endmodule

// File: rtl/tdm_rec_dp.sv
`timescale 1ns/1ps
module tdm_rec_dp
  import tdm_rec_pkg::*;
#(
  parameter int unsigned NUM_PRI = 16,
  parameter int unsigned NUM_AUX = 4,
  parameter int unsigned SMP_W   = 24
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrl_strb_t                 strb,
  input  logic [NUM_PRI*SMP_W-1:0]   priBank,
  input  logic [NUM_AUX*SMP_W-1:0]   auxBank,
  output logic                       sData,
  output logic                       fSync,
  output logic                       bitClkEn
);

  localparam int unsigned NUM_CH = NUM_PRI + NUM_AUX;
  localparam int unsigned CIDX   = $clog2(NUM_CH);

  logic [SMP_W-1:0] chanReg [NUM_CH];
  logic [SMP_W-1:0] shReg;
  logic [SMP_W-1:0] nextWord;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chanReg[g] <= '0;
      else if (strb.latch) begin
        if (g < NUM_PRI) chanReg[g] <= priBank[(g % NUM_PRI)*SMP_W +: SMP_W];
        else             chanReg[g] <= auxBank[((g - NUM_PRI) % NUM_AUX)*SMP_W +: SMP_W];
      end
    end
  end

  always_comb begin
    nextWord = '0;
    if (strb.chSel < CH_W'(NUM_CH)) nextWord = chanReg[strb.chSel[CIDX-1:0]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      sData    <= 1'b0;
      fSync    <= 1'b0;
      bitClkEn <= 1'b0;
    end else begin
      bitClkEn <= strb.tick;
      if (strb.loadWord)     shReg <= nextWord;
      else if (strb.emitBit) shReg <= shReg << 1;
      if (strb.tick) begin
        sData <= strb.emitBit & shReg[SMP_W-1];
        fSync <= strb.syncVal;
      end
    end
  end

  // R13
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.tick |=> ($stable(sData) && $stable(fSync)));

  // R2
  en_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |=> bitClkEn);

  // R11
  zero_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.emitBit) |=> !sData);

endmodule

// File: rtl/tdm_rec_serializer.sv
`timescale 1ns/1ps
module tdm_rec_serializer
  import tdm_rec_pkg::*;
#(
  parameter int unsigned NUM_PRI   = 16,
  parameter int unsigned NUM_AUX   = 4,
  parameter int unsigned SMP_W     = 24,
  parameter int unsigned CLK_DIV   = 2,
  parameter int unsigned MAX_FRAME = 384
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleStb,
  input  logic [NUM_PRI*SMP_W-1:0] priBank,
  input  logic [NUM_AUX*SMP_W-1:0] auxBank,
  input  logic                     dspMode,
  input  logic                     auxOrder,
  input  logic                     auxEn,
  input  logic [1:0]               wordSel,
  input  logic [2:0]               rateSel,
  output logic                     sData,
  output logic                     fSync,
  output logic                     bitClkEn
);

  ctrl_strb_t strb;

  tdm_rec_ctrl #(
    .NUM_PRI(NUM_PRI), .NUM_AUX(NUM_AUX), .CLK_DIV(CLK_DIV), .MAX_FRAME(MAX_FRAME)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .dspMode(dspMode),
    .auxOrder(auxOrder), .auxEn(auxEn), .wordSel(wordSel), .rateSel(rateSel),
    .strb(strb)
  );

  tdm_rec_dp #(
    .NUM_PRI(NUM_PRI), .NUM_AUX(NUM_AUX), .SMP_W(SMP_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .priBank(priBank), .auxBank(auxBank),
    .sData(sData), .fSync(fSync), .bitClkEn(bitClkEn)
  );

endmodule

// File: tb/tdm_rec_serializer_test.sv
`timescale 1ns/1ps
module tdm_rec_serializer_test;

  localparam int NP = 16;
  localparam int NA = 4;
  localparam int SW = 24;
  localparam int DIV = 2;
  localparam int NC = NP + NA;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleStb = 1'b0;
  logic [NP*SW-1:0] priBank = '0;
  logic [NA*SW-1:0] auxBank = '0;
  logic dspMode = 1'b0, auxOrder = 1'b0, auxEn = 1'b0;
  logic [1:0] wordSel = '0;
  logic [2:0] rateSel = '0;
  logic sData, fSync, bitClkEn;

  always #2.5 clk = ~clk;

  tdm_rec_serializer uut (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .priBank(priBank), .auxBank(auxBank),
    .dspMode(dspMode), .auxOrder(auxOrder), .auxEn(auxEn), .wordSel(wordSel),
    .rateSel(rateSel), .sData(sData), .fSync(fSync), .bitClkEn(bitClkEn)
  );

  typedef struct { bit s; bit d; bit first; string rq; } exp_t;
  exp_t expQ[$];
  int errs = 0, checks = 0;
  int enCnt = 0, cyc = 0, lastEnCyc = 0;
  bit monOn = 0, done = 0;
  bit prevD = 0, prevS = 0;
  logic [SW-1:0] smp [NC];
  int seq0[$], seq1[$];

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int flen(input int r, input int ws);
    case (r)
      0: return 256;
      1: return 320;
      2: return 384;
      3: return 64;
      4: return (ws == 1) ? 128 : 256;
      default: return 256;
    endcase
  endfunction

  function automatic int wlen(input int ws);
    if (ws == 1) return 8;
    if (ws == 2) return 24;
    return 16;
  endfunction

  // Slot lists; aux channel k (X1..X4) is index 16+k-1.
  function automatic void buildSeq(input bit dsp, input bit ord, input bit aux);
    int run[$];
    seq0.delete(); seq1.delete();
    if (!aux) for (int c = 0; c < NP; c++) run.push_back(c);
    else if (!ord) begin
      for (int c = 0; c < NP; c++) run.push_back(c);
      if (dsp) for (int k = 0; k < NA; k++) run.push_back(NP + k);
    end else begin
      for (int k = 0; k < NA; k++) begin
        for (int j = 0; j < 4; j++) run.push_back(4 * k + j);
        run.push_back(NP + k);
      end
    end
    if (dsp) begin seq0 = run; return; end
    for (int i = 0; i < run.size(); i++)
      if (i < run.size() / 2) seq0.push_back(run[i]); else seq1.push_back(run[i]);
    if (aux && !ord) begin
      seq0.push_back(NP); seq0.push_back(NP + 1);
      seq1.push_back(NP + 2); seq1.push_back(NP + 3);
    end
  endfunction

  int curLen;

  task automatic startFrame(input bit dsp, input bit ord, input bit aux, input int ws,
                            input int rt, input string rq, input int seed);
    int L, W, H, q, sl, base;
    bit ph;
    exp_t e;
    for (int c = 0; c < NC; c++) smp[c] = SW'(c * 32'h1F3A7 + seed * 32'h9E37 + 32'h5A5A5);
    for (int c = 0; c < NP; c++) priBank[c*SW +: SW] = smp[c];
    for (int c = 0; c < NA; c++) auxBank[c*SW +: SW] = smp[NP + c];
    L = flen(rt, ws); W = wlen(ws); H = L / 2; curLen = L;
    buildSeq(dsp, ord, aux);
    for (int b = 0; b < L; b++) begin
      ph = !dsp && (b >= H);
      base = ph ? H : 0;
      q = b - base - 1;
      e.s = dsp ? (b == 0) : (b >= H);
      e.d = 1'b0;
      e.first = (b == 0);
      e.rq = rq;
      if (q >= 0) begin
        sl = q / W;
        if (!ph && sl < seq0.size()) e.d = smp[seq0[sl]][SW - 1 - (q % W)];
        if (ph && sl < seq1.size())  e.d = smp[seq1[sl]][SW - 1 - (q % W)];
      end
      expQ.push_back(e);
    end
    enCnt = 0;
    @(negedge clk);
    dspMode = dsp; auxOrder = ord; auxEn = aux; wordSel = 2'(ws); rateSel = 3'(rt);
    sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0;
  endtask

  task automatic endFrame();
    while (expQ.size() > 0) @(negedge clk);
    repeat (4 * DIV) @(negedge clk);
    // R3: number of bit periods in the frame
    chk(enCnt == curLen, "R3", "enables per frame", enCnt, curLen);
  endtask

  task automatic runFrame(input bit dsp, input bit ord, input bit aux, input int ws,
                          input int rt, input string rq, input int seed);
    startFrame(dsp, ord, aux, ws, rt, rq, seed);
    endFrame();
  endtask

  always @(negedge clk) begin
    cyc++;
    if (monOn && !done) begin
      if (bitClkEn) begin
        enCnt++;
        if (expQ.size() == 0) begin
          chk(0, "R2", "enable outside frame", 1, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          if (!e.first) chk(cyc - lastEnCyc == DIV, "R2", "enable spacing", cyc - lastEnCyc, DIV);
          chk(fSync == e.s, "R10", "frame sync", int'(fSync), int'(e.s));
          chk(sData == e.d, e.rq, "serial data", int'(sData), int'(e.d));
        end
        lastEnCyc = cyc;
      end else begin
        // R13: outputs hold between enables
        chk(sData == prevD && fSync == prevS, "R13", "hold between enables",
            int'({sData, fSync}), int'({prevD, prevS}));
      end
    end
    prevD = sData; prevS = fSync;
  end

  always @(posedge clk) begin
    if (cyc >= 150000 && !done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sData == 0 && fSync == 0 && bitClkEn == 0, "R1", "outputs in reset",
        int'({sData, fSync, bitClkEn}), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk(sData == 0 && fSync == 0 && bitClkEn == 0, "R1", "outputs after reset",
        int'({sData, fSync, bitClkEn}), 0);
    monOn = 1;

    runFrame(0, 0, 1, 0, 0, "R5", 1);   // I2S appended, 16-bit, 256
    runFrame(1, 0, 1, 0, 1, "R6", 2);   // DSP appended, 16-bit, 320
    runFrame(0, 1, 1, 1, 0, "R7", 3);   // I2S interleaved, 8-bit
    runFrame(1, 1, 1, 1, 4, "R8", 4);   // DSP interleaved, 8-bit, 128 (R11 cut)
    runFrame(0, 1, 0, 0, 2, "R9", 5);   // aux off, order ignored
    runFrame(1, 0, 0, 2, 2, "R4", 6);   // 24-bit, 384, last slot cut (R11)
    runFrame(0, 1, 1, 2, 2, "R11", 7);  // I2S 24-bit phases overrun and are cut
    runFrame(1, 0, 1, 3, 3, "R4", 8);   // width 3 acts as 16-bit, 64 periods
    runFrame(0, 0, 1, 0, 4, "R3", 9);   // rate 4 without 8-bit -> 256
    runFrame(1, 1, 1, 0, 6, "R3", 10);  // rate 6 -> 256

    // R12: mid-frame strobe with changed bank and settings is ignored
    startFrame(0, 0, 1, 0, 0, "R12", 11);
    repeat (60) @(negedge clk);
    priBank = '1; auxBank = '1; dspMode = 1; auxOrder = 1; wordSel = 2'd2; rateSel = 3'd3;
    sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0;
    endFrame();

    runFrame(1, 1, 0, 1, 0, "R9", 12);  // DSP aux off with order 1

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule